// File: doc/BRIEF.md
# Single-Precision Compare, Min/Max and Classify Unit

This unit performs the non-rounding operations on IEEE 754 single-precision operands: quiet equality, signaling less-than and less-or-equal, minimum-number and maximum-number selection, three kinds of sign injection, and a ten-way classification of the first operand. No result is ever rounded, so the unit needs neither a rounding mode nor any arithmetic datapath. It only decodes fields, compares magnitudes and selects among operands.

An operation starts when `in_valid` is high on a rising clock edge. The code on `op` and the two operands are sampled there, and the result and flag vector appear, registered, on the following edge together with `out_valid`. The flag vector has five bits. Bit 4 is the invalid-operation flag. Bits 3:0 stand for the divide-by-zero, overflow, underflow and inexact positions and remain zero, because none of these operations can raise them.

Top module: `fp_cmpsel_unit`

## Requirements
- R1: Opcodes 0 (equal), 1 (less-than) and 2 (less-or-equal) return 1 in result bit 0 when the relation holds and 0 otherwise, with result bits 31:1 zero. Any NaN operand gives 0.
- R2: Less-than and less-or-equal set flags bit 4 (invalid) when either operand is any NaN. Equal sets it only for a signaling NaN. Flags bits 3:0 are zero for every operation.
- R3: Equal reports +0 (0x00000000) and -0 (0x80000000) as equal. Less-than(-0,+0) is 0 and less-or-equal(-0,+0) is 1.
- R4: Opcodes 3 (minimum) and 4 (maximum) return the smaller or larger operand, and for these two opcodes -0 ranks below +0.
- R5: When both min/max operands are NaN the result is 0x7fc00000. When exactly one operand is NaN, the other operand is returned bit for bit.
- R6: A signaling NaN on either min/max operand sets flags bit 4, even when the result is not a NaN.
- R7: Opcodes 5, 6 and 7 return operand A bits 30:0 with a sign bit equal to B's sign, the inverse of B's sign, or A's sign XOR B's sign respectively. NaN payloads pass unchanged and the flags are zero.
- R8: Opcode 8 returns a one-hot mask of A in bits 9:0, with bits 31:10 zero and flags zero. Bit 0 is -inf, bit 1 negative normal, bit 2 negative subnormal, bit 3 -0, bit 4 +0, bit 5 positive subnormal, bit 6 positive normal, bit 7 +inf, bit 8 signaling NaN and bit 9 quiet NaN.
- R9: A NaN (exponent all ones, mantissa nonzero) is signaling when mantissa bit 22 is clear and quiet when it is set.
- R10: `out_valid` is high on the cycle after a cycle with `in_valid` high, and low after a cycle with `in_valid` low.
- R11: While `in_valid` is low, `result` and `flags` keep their values whatever `op`, `opnd_a` and `opnd_b` do.
- R12: Opcodes 9 to 15 return a result of zero and flags of zero.
- R13: While `rst` is high, `out_valid`, `result` and `flags` are all zero one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Starts an operation on this edge |
| op | input | 4 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| out_valid | output | 1 | Registered result is new this cycle |
| result | output | 32 | Registered result |
| flags | output | 5 | Registered exception flags, bit 4 invalid |

## Verification
The assertions assume that `in_valid` is never X or Z after reset. They check `op`, `opnd_a` and `opnd_b` only through the registered result, so the assertions place no constraint on operand values. The stimulus drives every input to a defined value at time zero and changes inputs only on falling edges. It uses opcodes 9 and 15 on purpose to reach the reserved-code assertion. The hold check changes the operands while `in_valid` is low, which exercises the stability property and the behaviour specified by R11.

// File: rtl/fpcu_pkg.sv
`timescale 1ns/1ps
package fpcu_pkg;
  localparam int FLAG_W  = 5;
  localparam int NV_POS  = 4;
  localparam int CLASS_W = 10;

  typedef enum logic [3:0] {
    OP_EQ    = 4'd0,
    OP_LT    = 4'd1,
    OP_LE    = 4'd2,
    OP_MIN   = 4'd3,
    OP_MAX   = 4'd4,
    OP_SGNJ  = 4'd5,
    OP_SGNJN = 4'd6,
    OP_SGNJX = 4'd7,
    OP_CLASS = 4'd8
  } fpcu_op_e;
endpackage

// File: rtl/fpcu_decode.sv
`timescale 1ns/1ps
module fpcu_decode import fpcu_pkg::*; #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0]       a,
  input  logic [W-1:0]       b,
  output logic [1:0]         is_nan,
  output logic [1:0]         is_snan,
  output logic [1:0]         is_zero,
  output logic [CLASS_W-1:0] a_mask
);
  logic [W-1:0] opnd [2];
  logic [1:0]   e_ones, e_zero, m_zero, q_bit;

  assign opnd[0] = a;
  assign opnd[1] = b;

  // per-operand field decode, same structure for both inputs
  for (genvar i = 0; i < 2; i++) begin : g_opnd
    assign e_ones[i]  = &opnd[i][W-2:MAN_W];
    assign e_zero[i]  = ~|opnd[i][W-2:MAN_W];
    assign m_zero[i]  = ~|opnd[i][MAN_W-1:0];
    assign q_bit[i]   = opnd[i][MAN_W-1];
    assign is_nan[i]  = e_ones[i] & ~m_zero[i];
    assign is_snan[i] = is_nan[i] & ~q_bit[i];
    assign is_zero[i] = e_zero[i] & m_zero[i];
  end

  logic neg, inf, norm, sub;
  assign neg  = a[W-1];
  assign inf  = e_ones[0] & m_zero[0];
  assign norm = ~e_ones[0] & ~e_zero[0];
  assign sub  = e_zero[0] & ~m_zero[0];

  assign a_mask = {is_nan[0] & q_bit[0], is_snan[0],
                   ~neg & inf, ~neg & norm, ~neg & sub, ~neg & is_zero[0],
                   neg & is_zero[0], neg & sub, neg & norm, neg & inf};
endmodule

// File: rtl/fpcu_compare.sv
`timescale 1ns/1ps
module fpcu_compare #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   is_nan,
  input  logic [1:0]   is_zero,
  output logic         eq,
  output logic         lt,
  output logic         le,
  output logic         lt_tot   // -0 below +0; meaningful for non-NaN only
);
  logic any_nan, both_zero, sa, sb, mag_lt, mag_gt, same_sign_lt;

  assign any_nan      = |is_nan;
  assign both_zero    = &is_zero;
  assign sa           = a[W-1];
  assign sb           = b[W-1];
  assign mag_lt       = a[W-2:0] < b[W-2:0];
  assign mag_gt       = a[W-2:0] > b[W-2:0];
  assign same_sign_lt = sa ? mag_gt : mag_lt;

  assign lt     = ~any_nan & ((sa != sb) ? (sa & ~both_zero) : same_sign_lt);
  assign eq     = ~any_nan & ((a == b) | both_zero);
  assign le     = lt | eq;
  assign lt_tot = (sa != sb) ? sa : same_sign_lt;
endmodule

// File: rtl/fpcu_minmax.sv
`timescale 1ns/1ps
module fpcu_minmax #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   is_nan,
  input  logic [1:0]   is_snan,
  input  logic         lt_tot,
  input  logic         pick_max,
  output logic [W-1:0] res,
  output logic         invalid
);
  localparam logic [W-1:0] CANON_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  assign invalid = |is_snan;

  always_comb begin
    unique case (is_nan)
      2'b11:   res = CANON_NAN;
      2'b01:   res = b;
      2'b10:   res = a;
      default: res = (lt_tot ^ pick_max) ? a : b;
    endcase
  end
endmodule

// File: rtl/fp_cmpsel_unit.sv
`timescale 1ns/1ps
module fp_cmpsel_unit import fpcu_pkg::*; #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic [W-1:0]      opnd_a,
  input  logic [W-1:0]      opnd_b,
  output logic              out_valid,
  output logic [W-1:0]      result,
  output logic [FLAG_W-1:0] flags
);
  localparam logic [W-1:0] CANON_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic [1:0]         is_nan, is_snan, is_zero;
  logic [CLASS_W-1:0] a_mask;
  logic               eq, lt, le, lt_tot, mm_inv;
  logic [W-1:0]       mm_res;

  fpcu_decode #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_decode (
    .a(opnd_a), .b(opnd_b), .is_nan(is_nan), .is_snan(is_snan),
    .is_zero(is_zero), .a_mask(a_mask));

  fpcu_compare #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_compare (
    .a(opnd_a), .b(opnd_b), .is_nan(is_nan), .is_zero(is_zero),
    .eq(eq), .lt(lt), .le(le), .lt_tot(lt_tot));

  fpcu_minmax #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_minmax (
    .a(opnd_a), .b(opnd_b), .is_nan(is_nan), .is_snan(is_snan),
    .lt_tot(lt_tot), .pick_max(op == OP_MAX), .res(mm_res), .invalid(mm_inv));

  logic [W-1:0] nxt_res;
  logic         nxt_inv;

  always_comb begin
    nxt_res = '0;
    nxt_inv = 1'b0;
    case (op)
      OP_EQ:    begin nxt_res[0] = eq; nxt_inv = |is_snan; end
      OP_LT:    begin nxt_res[0] = lt; nxt_inv = |is_nan;  end
      OP_LE:    begin nxt_res[0] = le; nxt_inv = |is_nan;  end
      OP_MIN,
      OP_MAX:   begin nxt_res = mm_res; nxt_inv = mm_inv; end
      OP_SGNJ:  nxt_res = {opnd_b[W-1], opnd_a[W-2:0]};
      OP_SGNJN: nxt_res = {~opnd_b[W-1], opnd_a[W-2:0]};
      OP_SGNJX: nxt_res = {opnd_a[W-1] ^ opnd_b[W-1], opnd_a[W-2:0]};
      OP_CLASS: nxt_res[CLASS_W-1:0] = a_mask;
      default:  ;
    endcase
  end

  logic [3:0] op_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags     <= '0;
      op_q      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= nxt_res;
        flags  <= {nxt_inv, {NV_POS{1'b0}}};
        op_q   <= op;
      end
    end
  end

  // ---------------- assertions ----------------
  logic res_is_nan;
  assign res_is_nan = (&result[W-2:MAN_W]) & (|result[MAN_W-1:0]);

  p_cmp_boolean_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid && (op_q == OP_EQ || op_q == OP_LT || op_q == OP_LE)
      |-> result[W-1:1] == '0);

  p_spare_flags_r2: assert property (@(posedge clk) disable iff (rst)
    flags[NV_POS-1:0] == '0);

  p_minmax_canon_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid && (op_q == OP_MIN || op_q == OP_MAX) && res_is_nan
      |-> result == CANON_NAN);

  p_sgnj_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && (op_q == OP_SGNJ || op_q == OP_SGNJN || op_q == OP_SGNJX)
      |-> flags == '0);

  p_class_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && op_q == OP_CLASS
      |-> $onehot(result[CLASS_W-1:0]) && result[W-1:CLASS_W] == '0 && flags == '0);

  p_valid_rise_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_fall_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result) && $stable(flags));

  p_reserved_zero_r12: assert property (@(posedge clk) disable iff (rst)
    out_valid && op_q > 4'd8 |-> result == '0 && flags == '0);
endmodule

// File: tb/fp_cmpsel_unit_bench.sv
`timescale 1ns/1ps
module fp_cmpsel_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [31:0] opnd_a = 32'h0;
  logic [31:0] opnd_b = 32'h0;
  logic        out_valid;
  logic [31:0] result;
  logic [4:0]  flags;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 4 ns period, 250 MHz

  fp_cmpsel_unit u_fp_cmpsel_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b),
    .out_valid(out_valid), .result(result), .flags(flags));

  typedef struct packed {
    logic [3:0]  req;
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic [4:0]  fl;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 4'd0, 32'h3f800000, 32'h3f800000, 32'h00000001, 5'h00}, // R1 1==1
    '{4'd1, 4'd0, 32'h3f800000, 32'h40000000, 32'h00000000, 5'h00}, // R1 1==2
    '{4'd1, 4'd1, 32'h3f800000, 32'h40000000, 32'h00000001, 5'h00}, // R1 1<2
    '{4'd1, 4'd1, 32'h40000000, 32'h3f800000, 32'h00000000, 5'h00}, // R1 2<1
    '{4'd1, 4'd1, 32'hc0000000, 32'hbf800000, 32'h00000001, 5'h00}, // R1 -2<-1
    '{4'd1, 4'd2, 32'h40000000, 32'h40000000, 32'h00000001, 5'h00}, // R1 2<=2
    '{4'd1, 4'd2, 32'h7f800000, 32'hff800000, 32'h00000000, 5'h00}, // R1 inf<=-inf
    '{4'd3, 4'd0, 32'h00000000, 32'h80000000, 32'h00000001, 5'h00}, // R3 +0==-0
    '{4'd3, 4'd1, 32'h80000000, 32'h00000000, 32'h00000000, 5'h00}, // R3 -0<+0
    '{4'd3, 4'd2, 32'h80000000, 32'h00000000, 32'h00000001, 5'h00}, // R3 -0<=+0
    '{4'd2, 4'd0, 32'h7fc00000, 32'h3f800000, 32'h00000000, 5'h00}, // R2 eq qNaN
    '{4'd2, 4'd0, 32'h7f800001, 32'h3f800000, 32'h00000000, 5'h10}, // R2 eq sNaN
    '{4'd2, 4'd1, 32'h7fc00000, 32'h3f800000, 32'h00000000, 5'h10}, // R2 lt qNaN
    '{4'd2, 4'd2, 32'h3f800000, 32'h7fc00000, 32'h00000000, 5'h10}, // R2 le qNaN
    '{4'd4, 4'd3, 32'h00000000, 32'h80000000, 32'h80000000, 5'h00}, // R4 min(+0,-0)
    '{4'd4, 4'd4, 32'h80000000, 32'h00000000, 32'h00000000, 5'h00}, // R4 max(-0,+0)
    '{4'd4, 4'd3, 32'h3f800000, 32'hc0000000, 32'hc0000000, 5'h00}, // R4 min(1,-2)
    '{4'd4, 4'd4, 32'h3f800000, 32'hc0000000, 32'h3f800000, 5'h00}, // R4 max(1,-2)
    '{4'd4, 4'd4, 32'hff800000, 32'h7f800000, 32'h7f800000, 5'h00}, // R4 max(-inf,inf)
    '{4'd5, 4'd3, 32'h7fc00123, 32'h40000000, 32'h40000000, 5'h00}, // R5 one NaN
    '{4'd5, 4'd4, 32'h7fc00123, 32'h7f800001, 32'h7fc00000, 5'h10}, // R5 both NaN
    '{4'd6, 4'd3, 32'h7f800001, 32'h3f800000, 32'h3f800000, 5'h10}, // R6 sNaN in min
    '{4'd7, 4'd5, 32'h3f800000, 32'hbf800000, 32'hbf800000, 5'h00}, // R7 copy sign
    '{4'd7, 4'd6, 32'h3f800000, 32'hbf800000, 32'h3f800000, 5'h00}, // R7 inverse sign
    '{4'd7, 4'd7, 32'hbf800000, 32'hbf800000, 32'h3f800000, 5'h00}, // R7 xor sign
    '{4'd7, 4'd6, 32'h7f800001, 32'h00000000, 32'hff800001, 5'h00}, // R7 NaN unchanged
    '{4'd8, 4'd8, 32'hff800000, 32'h0,        32'h00000001, 5'h00}, // R8 -inf
    '{4'd8, 4'd8, 32'hbf800000, 32'h0,        32'h00000002, 5'h00}, // R8 neg normal
    '{4'd8, 4'd8, 32'h80000001, 32'h0,        32'h00000004, 5'h00}, // R8 neg subnormal
    '{4'd8, 4'd8, 32'h80000000, 32'h0,        32'h00000008, 5'h00}, // R8 -0
    '{4'd8, 4'd8, 32'h00000000, 32'h0,        32'h00000010, 5'h00}, // R8 +0
    '{4'd8, 4'd8, 32'h00000001, 32'h0,        32'h00000020, 5'h00}, // R8 pos subnormal
    '{4'd8, 4'd8, 32'h3f800000, 32'h0,        32'h00000040, 5'h00}, // R8 pos normal
    '{4'd8, 4'd8, 32'h7f800000, 32'h0,        32'h00000080, 5'h00}, // R8 +inf
    '{4'd9, 4'd8, 32'h7f800001, 32'h0,        32'h00000100, 5'h00}, // R9 sNaN
    '{4'd9, 4'd8, 32'h7fbfffff, 32'h0,        32'h00000100, 5'h00}, // R9 sNaN full payload
    '{4'd9, 4'd8, 32'hffc00000, 32'h0,        32'h00000200, 5'h00}, // R9 qNaN
    '{4'd12, 4'd9, 32'h3f800000, 32'h3f800000, 32'h00000000, 5'h00} // R12 reserved
  };

  task automatic check(input int req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  // drive one operation; returns at the falling edge after the capturing edge
  task automatic issue(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    in_valid = 1'b1; op = o; opnd_a = a; opnd_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R13 reset state
    repeat (3) @(negedge clk);
    check(13, "reset out_valid", {31'b0, out_valid}, 32'h0);
    check(13, "reset result", result, 32'h0);
    check(13, "reset flags", {27'b0, flags}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].op, VECS[i].a, VECS[i].b);
      check(VECS[i].req, $sformatf("vec %0d result", i), result, VECS[i].res);
      check(VECS[i].req, $sformatf("vec %0d flags", i), {27'b0, flags}, {27'b0, VECS[i].fl});
    end

    // R12 top reserved code
    issue(4'd15, 32'h7f800001, 32'h7f800001);
    check(12, "op 15 result", result, 32'h0);
    check(12, "op 15 flags", {27'b0, flags}, 32'h0);

    // R10 latency: valid the cycle after issue, low the cycle after that
    issue(4'd1, 32'h3f800000, 32'h40000000);
    check(10, "out_valid after issue", {31'b0, out_valid}, 32'h1);
    @(negedge clk);
    check(10, "out_valid idle", {31'b0, out_valid}, 32'h0);

    // R11 hold while idle with changing inputs
    issue(4'd4, 32'h7f800001, 32'h40000000);   // result 0x40000000, invalid set
    for (int k = 0; k < 3; k++) begin
      op = 4'(k + 5); opnd_a = 32'hdeadbeef + 32'(k); opnd_b = 32'h80000000;
      @(negedge clk);
    end
    check(11, "held result", result, 32'h40000000);
    check(11, "held flags", {27'b0, flags}, 32'h10);

    // R13 reset mid-run
    issue(4'd3, 32'hc0000000, 32'h3f800000);
    check(4, "min before reset", result, 32'hc0000000);
    rst = 1'b1;
    @(negedge clk);
    check(13, "mid reset result", result, 32'h0);
    check(13, "mid reset out_valid", {31'b0, out_valid}, 32'h0);
    rst = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule